// File: doc/BRIEF.md
# Per-Block Write Protection Array

This block keeps the write-protection state of N flash blocks. Every block owns a persistent protection bit and a volatile protection bit. Both use an active-low code: 0 means protected and 1 means open. A shared lock bit decides whether the persistent bits may change. A write-protect pin, when driven low, also closes a parameter-chosen set of boot blocks.

The block takes decoded commands. It raises one protected flag per block, which the write path of the flash consults. When it refuses a command it gives a one-cycle rejection pulse. The command port has no back-pressure: there is no ready signal, and every cycle with `cmd_valid` high is taken and acted on at that clock edge.

The persistent bits model storage that outlives a hardware reset and a power cycle. Their registers are never reset and start erased (all 1). The hardware reset and the power-cycle pulse both bring the lock back to open and reload the volatile bits from `VOL_INIT`.

Top module: `blkprot_top`

## Requirements
- R1: `prot_o[i]` is 1 when the persistent bit of block i is 0 or its volatile bit is 0. It is 0 when both bits are 1 and block i is not forced by R9.
- R2: The command op code 0 with `cmd_blk` < N programs that block's persistent bit to 0 while the lock is open. No other block changes.
- R3: The op code 1 returns every persistent bit to 1 at once while the lock is open. No command returns a single persistent bit to 1.
- R4: The op code 4 closes the lock. While the lock is closed, op codes 0 and 1 leave all bits unchanged and are rejected.
- R5: A closed lock opens again only when `hw_rst_n` is low or `pwr_cyc` is pulsed. Repeating op code 4 or issuing any other command does not open it.
- R6: Persistent bits keep their values through a low `hw_rst_n` and through a `pwr_cyc` pulse.
- R7: The op code 2 programs the volatile bit of block `cmd_blk` to 0, and the op code 3 returns it to 1. Both work whatever the lock state is.
- R8: Volatile bits load `VOL_INIT` (default all 1) when `hw_rst_n` is low and when `pwr_cyc` is pulsed.
- R9: While `wp_n` is 0, every block set in `BOOT_MASK` (default blocks 0 and 1) reads as protected. This holds whatever that block's bits are.
- R10: Op codes 0, 2 and 3 with `cmd_blk` >= N are ignored and rejected. The undefined op codes 5, 6 and 7 are also ignored and rejected.
- R11: `rej_o` is high for the one cycle that follows each rejected command. It is low after every accepted command or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Active-low hardware reset/power-up, asynchronous |
| pwr_cyc | input | 1 | Power-cycle indication, one-cycle pulse |
| wp_n | input | 1 | Write-protect pin, low forces boot blocks protected |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Op code: 0 persistent program, 1 persistent clear all, 2 volatile program, 3 volatile clear, 4 lock |
| cmd_blk | input | IDX_W | Block index for op codes 0, 2, 3 |
| prot_o | output | N | Per-block protected flag, 1 = protected |
| rej_o | output | 1 | Command rejected, one cycle after the command |

## Verification
The bench targets four things.

- **Lock gating.** It closes the lock, then issues persistent commands and repeats the lock command. A design that lets a command reopen the lock, or one that still writes while locked, shows the wrong flags.
- **Persistence across resets.** It checks that persistent protection survives both a hardware reset and a power-cycle pulse, and that the volatile bits reload on both. A design that resets the wrong bank loses block protection or keeps stale volatile protection.
- **Rejections.** It drives out-of-range indices, undefined op codes and rejected commands back to back. A design with a stretched or missing rejection pulse, or one that wraps the index onto a real block, is caught.
- **Overlaps.** It checks the OR of the two bits and the boot-block override by the write-protect pin. These expose a design that lets a volatile clear unprotect a block that its persistent bit holds.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
  typedef enum logic [2:0] {
    OP_NV_PROG    = 3'd0,
    OP_NV_CLR_ALL = 3'd1,
    OP_V_PROG     = 3'd2,
    OP_V_CLR      = 3'd3,
    OP_LOCK       = 3'd4
  } op_e;
endpackage

// File: rtl/blkprot_cmd_dec.sv
module blkprot_cmd_dec #(
  parameter int N     = 16,
  parameter int IDX_W = 5,
  localparam int IDX_N = (N > 1) ? $clog2(N) : 1
) (
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             lock_open,
  output logic             nv_prog,
  output logic             nv_clr_all,
  output logic             v_prog,
  output logic             v_clr,
  output logic             lock_set,
  output logic [IDX_N-1:0] blk_idx,
  output logic             reject
);
  import blkprot_pkg::*;

  logic in_range;
  assign in_range = (32'(cmd_blk) < N);
  assign blk_idx  = IDX_N'(cmd_blk);

  always_comb begin
    nv_prog    = 1'b0;
    nv_clr_all = 1'b0;
    v_prog     = 1'b0;
    v_clr      = 1'b0;
    lock_set   = 1'b0;
    reject     = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_op)
        OP_NV_PROG: begin
          if (in_range && lock_open) nv_prog = 1'b1;
          else                       reject  = 1'b1;
        end
        OP_NV_CLR_ALL: begin
          if (lock_open) nv_clr_all = 1'b1;
          else           reject     = 1'b1;
        end
        OP_V_PROG: begin
          if (in_range) v_prog = 1'b1;
          else          reject = 1'b1;
        end
        OP_V_CLR: begin
          if (in_range) v_clr  = 1'b1;
          else          reject = 1'b1;
        end
        OP_LOCK:  lock_set = 1'b1;
        default:  reject   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/blkprot_nv_bank.sv
module blkprot_nv_bank #(
  parameter int N = 16,
  localparam int IDX_N = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             pwr_cyc,
  input  logic             nv_prog,
  input  logic             nv_clr_all,
  input  logic             lock_set,
  input  logic [IDX_N-1:0] blk_idx,
  output logic [N-1:0]     nv_q,
  output logic             lock_q
);
  // Persistent storage: erased at start, never touched by any reset.
  logic [N-1:0] nv_r = '1;

  always_ff @(posedge clk) begin
    if (nv_clr_all)   nv_r <= '1;
    else if (nv_prog) nv_r[blk_idx] <= 1'b0;
  end

  // Lock: 1 = open, 0 = closed. Only reset or power cycle reopens it.
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)     lock_q <= 1'b1;
    else if (pwr_cyc)  lock_q <= 1'b1;
    else if (lock_set) lock_q <= 1'b0;
  end

  assign nv_q = nv_r;
endmodule

// File: rtl/blkprot_vol_bank.sv
module blkprot_vol_bank #(
  parameter int N = 16,
  parameter logic [N-1:0] VOL_INIT = '1,
  localparam int IDX_N = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             pwr_cyc,
  input  logic             v_prog,
  input  logic             v_clr,
  input  logic [IDX_N-1:0] blk_idx,
  output logic [N-1:0]     vol_q
);
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)    vol_q <= VOL_INIT;
    else if (pwr_cyc) vol_q <= VOL_INIT;
    else if (v_prog)  vol_q[blk_idx] <= 1'b0;
    else if (v_clr)   vol_q[blk_idx] <= 1'b1;
  end
endmodule

// File: rtl/blkprot_merge.sv
module blkprot_merge #(
  parameter int N = 16,
  parameter logic [N-1:0] BOOT_MASK = N'(3)
) (
  input  logic [N-1:0] nv_q,
  input  logic [N-1:0] vol_q,
  input  logic         wp_n,
  output logic [N-1:0] prot_o
);
  for (genvar i = 0; i < N; i++) begin : g_blk
    if (BOOT_MASK[i]) begin : g_boot
      assign prot_o[i] = ~nv_q[i] | ~vol_q[i] | ~wp_n;
    end else begin : g_plain
      assign prot_o[i] = ~nv_q[i] | ~vol_q[i];
    end
  end
endmodule

// File: rtl/blkprot_top.sv
module blkprot_top #(
  parameter int N     = 16,
  parameter int IDX_W = 5,
  parameter logic [N-1:0] VOL_INIT  = '1,
  parameter logic [N-1:0] BOOT_MASK = N'(3),
  localparam int IDX_N = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             pwr_cyc,
  input  logic             wp_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  output logic [N-1:0]     prot_o,
  output logic             rej_o
);
  logic             nv_prog, nv_clr_all, v_prog, v_clr, lock_set, reject;
  logic [IDX_N-1:0] blk_idx;
  logic [N-1:0]     nv_q, vol_q;
  logic             lock_q;

  blkprot_cmd_dec #(.N(N), .IDX_W(IDX_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .lock_open(lock_q), .nv_prog(nv_prog), .nv_clr_all(nv_clr_all),
    .v_prog(v_prog), .v_clr(v_clr), .lock_set(lock_set),
    .blk_idx(blk_idx), .reject(reject)
  );

  blkprot_nv_bank #(.N(N)) u_nv (
    .clk(clk), .hw_rst_n(hw_rst_n), .pwr_cyc(pwr_cyc),
    .nv_prog(nv_prog), .nv_clr_all(nv_clr_all), .lock_set(lock_set),
    .blk_idx(blk_idx), .nv_q(nv_q), .lock_q(lock_q)
  );

  blkprot_vol_bank #(.N(N), .VOL_INIT(VOL_INIT)) u_vol (
    .clk(clk), .hw_rst_n(hw_rst_n), .pwr_cyc(pwr_cyc),
    .v_prog(v_prog), .v_clr(v_clr), .blk_idx(blk_idx), .vol_q(vol_q)
  );

  blkprot_merge #(.N(N), .BOOT_MASK(BOOT_MASK)) u_merge (
    .nv_q(nv_q), .vol_q(vol_q), .wp_n(wp_n), .prot_o(prot_o)
  );

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) rej_o <= 1'b0;
    else           rej_o <= reject;
  end
endmodule

// File: rtl/blkprot_chk.sv
module blkprot_chk #(
  parameter int N = 16,
  parameter logic [N-1:0] BOOT_MASK = N'(3)
) (
  input logic         clk,
  input logic         hw_rst_n,
  input logic         pwr_cyc,
  input logic         wp_n,
  input logic         cmd_valid,
  input logic [N-1:0] prot_o,
  input logic         rej_o,
  input logic [N-1:0] nv_q,
  input logic [N-1:0] vol_q,
  input logic         lock_q
);
  p_or_merge_r1: assert property (@(posedge clk) disable iff (!hw_rst_n)
    &(prot_o | (nv_q & vol_q)));

  p_clear_all_only_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (|(nv_q & ~$past(nv_q))) |-> (&nv_q));

  p_locked_stable_r4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!lock_q && !pwr_cyc) |=> $stable(nv_q));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!lock_q && !pwr_cyc) |=> !lock_q);

  p_boot_forced_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !wp_n |-> &(prot_o | ~BOOT_MASK));

  p_rej_needs_cmd_r11: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !$past(cmd_valid) |-> !rej_o);
endmodule

bind blkprot_top blkprot_chk #(.N(N), .BOOT_MASK(BOOT_MASK)) u_chk (
  .clk(clk), .hw_rst_n(hw_rst_n), .pwr_cyc(pwr_cyc), .wp_n(wp_n),
  .cmd_valid(cmd_valid), .prot_o(prot_o), .rej_o(rej_o),
  .nv_q(nv_q), .vol_q(vol_q), .lock_q(lock_q)
);

// File: tb/blkprot_top_bench.sv
module blkprot_top_bench;
  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0;
  logic        pwr_cyc = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [4:0]  cmd_blk = 5'd0;
  logic [15:0] prot_o;
  logic        rej_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  blkprot_top u_blkprot_top (
    .clk(clk), .hw_rst_n(hw_rst_n), .pwr_cyc(pwr_cyc), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .prot_o(prot_o), .rej_o(rej_o)
  );

  // {valid, op, blk, wp_n, exp_prot, exp_rej}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 3'd0, 5'd3,  1'b1, 16'h0008, 1'b0},  // R2 program block 3
    {1'b1, 3'd2, 5'd5,  1'b1, 16'h0028, 1'b0},  // R7 volatile program 5
    {1'b1, 3'd0, 5'd20, 1'b1, 16'h0028, 1'b1},  // R10 out of range
    {1'b1, 3'd3, 5'd5,  1'b1, 16'h0008, 1'b0},  // R7 volatile clear 5
    {1'b1, 3'd2, 5'd3,  1'b1, 16'h0008, 1'b0},  // R1 overlap on block 3
    {1'b1, 3'd3, 5'd3,  1'b1, 16'h0008, 1'b0},  // R1 persistent still holds
    {1'b1, 3'd1, 5'd0,  1'b1, 16'h0000, 1'b0},  // R3 clear all
    {1'b1, 3'd0, 5'd15, 1'b1, 16'h8000, 1'b0},  // R2 top block
    {1'b1, 3'd0, 5'd0,  1'b0, 16'h8003, 1'b0},  // R9 wp low
    {1'b1, 3'd7, 5'd0,  1'b1, 16'h8001, 1'b1},  // R10 undefined op
    {1'b1, 3'd4, 5'd0,  1'b1, 16'h8001, 1'b0},  // R4 lock
    {1'b1, 3'd1, 5'd0,  1'b1, 16'h8001, 1'b1},  // R4 clear all locked
    {1'b1, 3'd0, 5'd9,  1'b1, 16'h8001, 1'b1},  // R4 program locked
    {1'b1, 3'd2, 5'd9,  1'b1, 16'h8201, 1'b0},  // R7 volatile while locked
    {1'b1, 3'd4, 5'd0,  1'b1, 16'h8201, 1'b0},  // R5 relock
    {1'b0, 3'd0, 5'd4,  1'b1, 16'h8201, 1'b0}   // R11 idle, no effect
  };
  localparam int VREQ [NV] = '{2, 7, 10, 7, 1, 1, 3, 2, 9, 10, 4, 4, 4, 7, 5, 11};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic both(input string req, input logic [15:0] ep, input logic er);
    chk(req, prot_o, ep);
    chk(req, {15'd0, rej_o}, {15'd0, er});
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [4:0] blk);
    cmd_valid = v; cmd_op = op; cmd_blk = blk;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    hw_rst_n = 1'b1;
    @(negedge clk);
    both("R8", 16'h0000, 1'b0);  // reset state

    for (int i = 0; i < NV; i++) begin
      wp_n = VEC[i][17];
      step(VEC[i][26], VEC[i][25:23], VEC[i][22:18]);
      both($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][16:1], VEC[i][0]);
    end

    // R6 R8: hardware reset keeps persistent, reloads volatile
    hw_rst_n = 1'b0; @(negedge clk); hw_rst_n = 1'b1; @(negedge clk);
    both("R6", 16'h8001, 1'b0);
    step(1'b1, 3'd1, 5'd0);
    both("R5", 16'h0000, 1'b0);   // lock reopened by reset
    step(1'b0, 3'd0, 5'd0);
    both("R11", 16'h0000, 1'b0);

    step(1'b1, 3'd0, 5'd7);  both("R2", 16'h0080, 1'b0);
    step(1'b1, 3'd2, 5'd12); both("R7", 16'h1080, 1'b0);
    step(1'b1, 3'd4, 5'd0);  both("R4", 16'h1080, 1'b0);
    pwr_cyc = 1'b1; @(negedge clk); pwr_cyc = 1'b0;
    both("R6 R8 pwr", 16'h0080, 1'b0);
    step(1'b1, 3'd0, 5'd2);  both("R5 pwr", 16'h0084, 1'b0);

    step(1'b1, 3'd4, 5'd0);  both("R4", 16'h0084, 1'b0);
    step(1'b1, 3'd0, 5'd4);  both("R4 rej", 16'h0084, 1'b1);
    step(1'b1, 3'd2, 5'd31); both("R10 vol oor", 16'h0084, 1'b1);
    step(1'b1, 3'd3, 5'd16); both("R10 clr oor", 16'h0084, 1'b1);
    step(1'b0, 3'd0, 5'd0);  both("R11 drop", 16'h0084, 1'b0);

    wp_n = 1'b0; @(negedge clk); both("R9", 16'h0087, 1'b0);
    wp_n = 1'b1; @(negedge clk); both("R9 release", 16'h0084, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule